// File: doc/BRIEF.md
# Lockstep Delayed-Compare Error Checker

This block sits between a primary processor and a shadow copy of it that runs a fixed number of cycles behind. Each cycle it takes the primary's output and architectural-state vector, holds it in a delay line, and compares it with the shadow's live vector. It also passes the primary's inputs through a delay line of the same length, so the shadow receives identical stimulus. This forwarded stream includes data the primary reads from its tightly coupled memories and its instruction cache, because the shadow has no memory access of its own.

The compared vector is a parameter-wide concatenation that the integrator assembles. Typically it holds the return address, stack pointer and frame pointer registers, the argument registers, the current and next program counters, and the machine status, trap, interrupt, counter and region-access control registers.

Any difference sets a sticky detection flag. The response then depends on a compile-time policy: report only, an interrupt with a halt request that an acknowledge releases, or an escalation request held until reset. The block also generates the shadow's reset. That reset asserts together with the primary's reset and releases a fixed number of cycles after it. Once debug mode has been entered, checking stays off until the next reset.

Top module: `lockstep_checker`

## Requirements
- R1: The delay parameter accepts only 2, 3 or 4; any other value stops elaboration with an error.
- R2: Once checking is active, a difference in any single bit between the primary vector from DELAY cycles earlier and the current shadow vector sets `err_flag` at the next clock edge.
- R3: While the delayed primary vector and the shadow vector agree, `err_flag`, `err_irq`, `halt_req` and `esc_req` stay low.
- R4: No comparison is made while `shadow_rst_n` is low, so a mismatch during the fill cycles after reset release has no effect.
- R5: `shadow_in` equals the value that `prim_in` had DELAY clock edges earlier.
- R6: `shadow_rst_n` is low whenever `rst_n` is low, going low at the same moment. It goes high at the DELAY-th rising edge after `rst_n` is released.
- R7: Once set, `err_flag` stays high until reset, even after the vectors agree again.
- R8: With the interrupt policy (value 1), `err_irq` and `halt_req` rise together with `err_flag`. A high `irq_ack` sampled at an edge clears both at that edge, while `err_flag` stays set.
- R9: With the escalation policy (value 2), `esc_req` rises together with `err_flag` and stays high until reset.
- R10: With the report-only policy (value 0), `err_irq`, `halt_req` and `esc_req` stay low. Under the interrupt policy `esc_req` stays low, and under the escalation policy `err_irq` and `halt_req` stay low.
- R11: After `dbg_mode` has been high at any clock edge, including the edge at which it is high, no mismatch sets `err_flag` until the next reset. This holds even after `dbg_mode` returns low.
- R12: Asserting `rst_n` clears `err_flag`, `err_irq`, `halt_req`, `esc_req` and the debug lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Common active-low reset, asynchronous assertion |
| dbg_mode | input | 1 | Primary core is in debug mode |
| irq_ack | input | 1 | Acknowledge of the mismatch interrupt |
| prim_vec | input | VEC_W | Primary core output and monitored-state vector |
| shadow_vec | input | VEC_W | Shadow core output and monitored-state vector |
| prim_in | input | IN_W | Inputs received by the primary core |
| shadow_in | output | IN_W | Delayed copy of `prim_in` for the shadow core |
| shadow_rst_n | output | 1 | Active-low reset for the shadow core |
| err_flag | output | 1 | Sticky mismatch detection |
| err_irq | output | 1 | Mismatch interrupt (interrupt policy) |
| halt_req | output | 1 | Halt request (interrupt policy) |
| esc_req | output | 1 | Escalation request (escalation policy) |

## Verification
The assertions take for granted that `shadow_vec` carries meaningful data only once `shadow_rst_n` is high. They also assume that `irq_ack` is pulsed only after an interrupt and that `dbg_mode` is a clean level synchronous to `clk`. The stimulus drives the shadow vector with deliberately wrong filler during the fill window, and with the primary's sequence shifted by the instance's delay afterwards. It flips exactly one bit per run, sweeping every bit position. The acknowledge pulse and the debug pulse are both driven on falling edges at chosen cycle indices. Three instances share the stimulus, covering each delay value and each policy.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

  typedef enum logic [1:0] {
    POL_REPORT    = 2'd0,
    POL_INTERRUPT = 2'd1,
    POL_ESCALATE  = 2'd2
  } err_policy_e;

  localparam int unsigned MIN_DELAY = 2;
  localparam int unsigned MAX_DELAY = 4;

endpackage

// File: rtl/lockstep_pipe.sv
module lockstep_pipe #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  // datapath flops carry no reset: contents are masked until the pipe fills
  always_ff @(posedge clk) begin
    stage_q[0] <= din;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/lockstep_rst_seq.sv
module lockstep_rst_seq #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic shadow_rst_n,
  output logic cmp_ready
);

  logic [DEPTH-1:0] rel_q;
  logic [DEPTH-1:0] rel_d;

  always_comb begin
    rel_d = {rel_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= '0;
    end else begin
      rel_q <= rel_d;
    end
  end

  assign cmp_ready    = rel_q[DEPTH-1];
  assign shadow_rst_n = rst_n & rel_q[DEPTH-1];

endmodule

// File: rtl/lockstep_err_ctl.sv
module lockstep_err_ctl
  import lockstep_pkg::*;
#(
  parameter err_policy_e POLICY = POL_REPORT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_ready,
  input  logic mismatch,
  input  logic dbg_mode,
  input  logic irq_ack,
  output logic err_flag,
  output logic err_irq,
  output logic halt_req,
  output logic esc_req
);

  logic lock_q, lock_d;
  logic flag_q, flag_d, flag_en;
  logic hit;

  always_comb begin
    hit     = cmp_ready & ~lock_q & ~dbg_mode & mismatch;
    lock_d  = 1'b1;
    flag_d  = 1'b1;
    flag_en = hit & ~flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (dbg_mode) begin
      lock_q <= lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign err_flag = flag_q;

  if (POLICY == POL_INTERRUPT) begin : g_irq
    logic irq_q, irq_d, irq_en;

    always_comb begin
      irq_en = hit | irq_ack;
      irq_d  = hit;            // a fresh mismatch wins over an acknowledge
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_q <= 1'b0;
      end else if (irq_en) begin
        irq_q <= irq_d;
      end
    end

    assign err_irq  = irq_q;
    assign halt_req = irq_q;
    assign esc_req  = 1'b0;
  end else if (POLICY == POL_ESCALATE) begin : g_esc
    logic esc_q, esc_en;

    always_comb begin
      esc_en = hit & ~esc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        esc_q <= 1'b0;
      end else if (esc_en) begin
        esc_q <= 1'b1;
      end
    end

    assign err_irq  = 1'b0;
    assign halt_req = 1'b0;
    assign esc_req  = esc_q;
  end else begin : g_report
    assign err_irq  = 1'b0;
    assign halt_req = 1'b0;
    assign esc_req  = 1'b0;
  end

endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker
  import lockstep_pkg::*;
#(
  parameter int unsigned DELAY  = 2,
  parameter int unsigned VEC_W  = 64,
  parameter int unsigned IN_W   = 32,
  parameter err_policy_e POLICY = POL_REPORT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_mode,
  input  logic             irq_ack,
  input  logic [VEC_W-1:0] prim_vec,
  input  logic [VEC_W-1:0] shadow_vec,
  input  logic [IN_W-1:0]  prim_in,
  output logic [IN_W-1:0]  shadow_in,
  output logic             shadow_rst_n,
  output logic             err_flag,
  output logic             err_irq,
  output logic             halt_req,
  output logic             esc_req
);

  // R1: only the supported skew values elaborate
  if (DELAY < MIN_DELAY || DELAY > MAX_DELAY) begin : g_bad_delay
    $error("lockstep_checker: DELAY must lie between 2 and 4");
  end

  logic [VEC_W-1:0] prim_vec_dly;
  logic             cmp_ready;
  logic             mismatch;

  lockstep_pipe #(.WIDTH(VEC_W), .DEPTH(DELAY)) u_vec_pipe (
    .clk  (clk),
    .din  (prim_vec),
    .dout (prim_vec_dly)
  );

  lockstep_pipe #(.WIDTH(IN_W), .DEPTH(DELAY)) u_in_pipe (
    .clk  (clk),
    .din  (prim_in),
    .dout (shadow_in)
  );

  lockstep_rst_seq #(.DEPTH(DELAY)) u_rst_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .shadow_rst_n (shadow_rst_n),
    .cmp_ready    (cmp_ready)
  );

  always_comb begin
    mismatch = |(prim_vec_dly ^ shadow_vec);
  end

  lockstep_err_ctl #(.POLICY(POLICY)) u_err_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_ready (cmp_ready),
    .mismatch  (mismatch),
    .dbg_mode  (dbg_mode),
    .irq_ack   (irq_ack),
    .err_flag  (err_flag),
    .err_irq   (err_irq),
    .halt_req  (halt_req),
    .esc_req   (esc_req)
  );

endmodule

// File: rtl/lockstep_checker_sva.sv
module lockstep_checker_sva
  import lockstep_pkg::*;
#(
  parameter err_policy_e POLICY = POL_REPORT
) (
  input logic clk,
  input logic rst_n,
  input logic dbg_mode,
  input logic shadow_rst_n,
  input logic err_flag,
  input logic err_irq,
  input logic halt_req,
  input logic esc_req
);

  logic seen_dbg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_dbg_q <= 1'b0;
    end else if (dbg_mode) begin
      seen_dbg_q <= 1'b1;
    end
  end

  always @(posedge clk) begin
    AST_SHADOW_RST_FOLLOWS: assert (rst_n || !shadow_rst_n); // R6
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R7

  AST_NO_FLAG_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(shadow_rst_n)); // R4

  AST_DEBUG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_dbg_q && !err_flag) |=> !err_flag); // R11

  AST_HALT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || err_irq) |-> err_flag); // R8

  AST_ESC_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |-> err_flag); // R9

  AST_ESC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |=> esc_req); // R9

  if (POLICY == POL_ESCALATE) begin : g_esc_chk
    AST_ESC_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> esc_req); // R9
  end else begin : g_noesc_chk
    AST_NO_ESC: assert property (@(posedge clk) disable iff (!rst_n)
      !esc_req); // R10
  end

  if (POLICY != POL_INTERRUPT) begin : g_noirq_chk
    AST_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !err_irq && !halt_req); // R10
  end

endmodule

bind lockstep_checker lockstep_checker_sva #(.POLICY(POLICY)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .dbg_mode     (dbg_mode),
  .shadow_rst_n (shadow_rst_n),
  .err_flag     (err_flag),
  .err_irq      (err_irq),
  .halt_req     (halt_req),
  .esc_req      (esc_req)
);

// File: tb/lockstep_checker_tb_top.sv
`timescale 1ns/1ps
module lockstep_checker_tb_top;
  import lockstep_pkg::*;

  localparam int W  = 12;
  localparam int IW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          dbg_mode;
  logic          irq_ack;
  logic [W-1:0]  prim_vec;
  logic [IW-1:0] prim_in;
  logic [W-1:0]  sv   [3];
  logic [IW-1:0] sin  [3];
  logic          sr   [3];
  logic          flag [3];
  logic          irq  [3];
  logic          halt [3];
  logic          esc  [3];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // index 0: report, delay 4; index 1: interrupt, delay 3; index 2: escalate, delay 2
  lockstep_checker #(.DELAY(4), .VEC_W(W), .IN_W(IW), .POLICY(POL_REPORT)) dut_p0 (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .irq_ack(irq_ack),
    .prim_vec(prim_vec), .shadow_vec(sv[0]), .prim_in(prim_in), .shadow_in(sin[0]),
    .shadow_rst_n(sr[0]), .err_flag(flag[0]), .err_irq(irq[0]), .halt_req(halt[0]),
    .esc_req(esc[0]));

  lockstep_checker #(.DELAY(3), .VEC_W(W), .IN_W(IW), .POLICY(POL_INTERRUPT)) dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .irq_ack(irq_ack),
    .prim_vec(prim_vec), .shadow_vec(sv[1]), .prim_in(prim_in), .shadow_in(sin[1]),
    .shadow_rst_n(sr[1]), .err_flag(flag[1]), .err_irq(irq[1]), .halt_req(halt[1]),
    .esc_req(esc[1]));

  lockstep_checker #(.DELAY(2), .VEC_W(W), .IN_W(IW), .POLICY(POL_ESCALATE)) dut_p2 (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .irq_ack(irq_ack),
    .prim_vec(prim_vec), .shadow_vec(sv[2]), .prim_in(prim_in), .shadow_in(sin[2]),
    .shadow_rst_n(sr[2]), .err_flag(flag[2]), .err_irq(irq[2]), .halt_req(halt[2]),
    .esc_req(esc[2]));

  function automatic int dl(int k);
    case (k)
      0:       return 4;
      1:       return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [W-1:0] fv(int n);
    return W'(n * 113 + 29);
  endfunction

  function automatic logic [IW-1:0] gi(int n);
    return IW'(n * 7 + 3);
  endfunction

  task automatic chk(string req, string what, int k, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s inst%0d actual=%0h expected=%0h", req, what, k, act, exp);
    end
  endtask

  task automatic drive(int n, logic [W-1:0] flip, logic dbg, logic ack);
    prim_vec = fv(n);
    prim_in  = gi(n);
    for (int k = 0; k < 3; k++) begin
      if (n >= dl(k)) sv[k] = fv(n - dl(k)) ^ flip;
      else            sv[k] = fv(n) ^ 12'hA5A;   // wrong filler during the fill window
    end
    dbg_mode = dbg;
    irq_ack  = ack;
  endtask

  task automatic check_common(int n);
    for (int k = 0; k < 3; k++) begin
      chk("R6", "shadow_rst_n", k, 32'(sr[k]), 32'(n >= dl(k)));
      if (n >= dl(k)) chk("R5", "shadow_in", k, 32'(sin[k]), 32'(gi(n - dl(k))));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drive(0, '0, 1'b0, 1'b0);
    #1;
    for (int k = 0; k < 3; k++) chk("R6", "shadow_rst_n in reset", k, 32'(sr[k]), 32'd0);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R12", "err_flag", k, 32'(flag[k]), 32'd0);
      chk("R12", "err_irq",  k, 32'(irq[k]),  32'd0);
      chk("R12", "halt_req", k, 32'(halt[k]), 32'd0);
      chk("R12", "esc_req",  k, 32'(esc[k]),  32'd0);
    end
    rst_n = 1'b1;
    drive(0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, '0, 1'b0, 1'b0);

    // clean run: no detection while the vectors agree (R3, R4 during fill)
    do_reset();
    for (int n = 1; n <= 40; n++) begin
      @(negedge clk);
      check_common(n);
      for (int k = 0; k < 3; k++) begin
        chk(n < dl(k) ? "R4" : "R3", "err_flag clean", k, 32'(flag[k]), 32'd0);
        chk("R3", "err_irq clean", k, 32'(irq[k]), 32'd0);
        chk("R3", "esc_req clean", k, 32'(esc[k]), 32'd0);
      end
      drive(n, '0, 1'b0, 1'b0);
    end

    // single-bit flip at every position at drive index 7, acknowledge at index 10
    for (int b = 0; b < W; b++) begin
      do_reset();
      for (int n = 1; n <= 13; n++) begin
        @(negedge clk);
        check_common(n);
        for (int k = 0; k < 3; k++) begin
          chk(n < dl(k) ? "R4" : (n < 8 ? "R3" : (n == 8 ? "R2" : "R7")),
              "err_flag", k, 32'(flag[k]), 32'(n >= 8));
          chk(k == 1 ? "R8" : "R10", "err_irq",  k, 32'(irq[k]),  32'(k == 1 && n >= 8 && n <= 10));
          chk(k == 1 ? "R8" : "R10", "halt_req", k, 32'(halt[k]), 32'(k == 1 && n >= 8 && n <= 10));
          chk(k == 2 ? "R9" : "R10", "esc_req",  k, 32'(esc[k]),  32'(k == 2 && n >= 8));
        end
        drive(n, (n == 7) ? W'(1 << b) : '0, 1'b0, n == 10);
      end
    end

    // debug lock: one-cycle debug pulse at index 5, mismatches at 8 and 9
    do_reset();
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      check_common(n);
      for (int k = 0; k < 3; k++) begin
        chk("R11", "err_flag after debug", k, 32'(flag[k]), 32'd0);
        chk("R11", "esc_req after debug",  k, 32'(esc[k]),  32'd0);
        chk("R11", "err_irq after debug",  k, 32'(irq[k]),  32'd0);
      end
      drive(n, (n == 8 || n == 9) ? '1 : '0, n == 5, 1'b0);
    end

    // debug and mismatch in the same cycle
    do_reset();
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++)
        chk("R11", "err_flag same-cycle debug", k, 32'(flag[k]), 32'd0);
      drive(n, (n == 6) ? '1 : '0, n == 6, 1'b0);
    end

    // reset clears the debug lock: detection works again
    do_reset();
    for (int n = 1; n <= 9; n++) begin
      @(negedge clk);
      for (int k = 0; k < 3; k++)
        chk(n < 7 ? "R3" : "R12", "err_flag after relock reset", k, 32'(flag[k]), 32'(n >= 7));
      drive(n, (n == 6) ? W'(12'h800) : '0, 1'b0, 1'b0);
    end

    do_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule